// File: doc/BRIEF.md
# Serial Quad-DAC Host Sequencer

This block sits on the host side of a four-channel, 12-bit serial digital-to-analog converter. It takes one update request at a time and turns it into a complete bus transaction. A request carries a channel number, a code and a batch flag, and is offered over a ready/valid handshake. The block drives the serial clock, the active-low select, the serial data line, an active-low strobe that loads the selected channel's input register, and an active-low strobe that moves every input register to the outputs together.

Every timing minimum on the bus is a parameter counted in system clock cycles. The defaults round the nanosecond figures up for a 100 MHz clock. The serial clock idles high, so each frame can end with the select rising while the clock is still high. The register-load strobe stays high for the whole time the select is low.

A request whose batch flag is set loads only its input register and leaves the outputs alone. The next request with the flag cleared ends with one all-load pulse, which updates every channel loaded since the previous pulse at the same time.

Top module: `qdac_seq`

## Requirements
- R1: After reset and whenever the block is idle, `dac_sclk`, `dac_cs_n`, `dac_ldreg_n` and `dac_ldall_n` are all high, `req_ready` is high and `busy` is low.
- R2: Each frame has exactly 16 rising edges of `dac_sclk` while `dac_cs_n` is low. The bits sampled at those edges are, in order: `req_chan[1]`, `req_chan[0]`, two zeros, then `req_code[11]` down to `req_code[0]`.
- R3: `dac_sdo` is stable for at least SETUP_CYC cycles before each rising clock edge and for at least HOLD_CYC cycles after it.
- R4: Every high phase of `dac_sclk` inside a frame lasts at least HIGH_CYC cycles, and every low phase lasts at least LOW_CYC cycles.
- R5: `dac_cs_n` falls at least CS_LEAD_CYC cycles before the first rising edge. It rises at least CS_LAG_CYC cycles after the last rising edge, and only while `dac_sclk` is high.
- R6: `dac_ldreg_n` stays high while `dac_cs_n` is low, and has been high for at least LREG_SETUP_CYC cycles at every rising clock edge. Each request produces exactly one low pulse of at least LREG_LOW_CYC cycles. That pulse begins after `dac_cs_n` has risen and at least LREG_AFTER_CYC cycles after the last rising edge.
- R7: When `req_hold` is 0, exactly one low pulse of at least LDALL_LOW_CYC cycles appears on `dac_ldall_n`, and it starts strictly after the register-load pulse has ended. When `req_hold` is 1, `dac_ldall_n` stays high for the whole request.
- R8: A request is taken only on a cycle with `req_valid` and `req_ready` both high. `busy` is high and `req_ready` is low from the cycle after acceptance until the last strobe pulse of that request has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_chan | input | CH_W | Target channel |
| req_code | input | CODE_W | Code for the channel, straight binary |
| req_hold | input | 1 | 1 = batch: leave the all-load pulse out |
| busy | output | 1 | Transaction in progress |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_cs_n | output | 1 | Active-low select |
| dac_sdo | output | 1 | Serial data, MSB first |
| dac_ldreg_n | output | 1 | Active-low load of the selected input register |
| dac_ldall_n | output | 1 | Active-low transfer of all input registers to the outputs |

## Verification
The assertions assume that the requester keeps `req_chan`, `req_code` and `req_hold` steady on any cycle where `req_valid` is high. They also assume that `req_valid` is low during reset. The bench drives and releases these inputs only on falling clock edges, and raises `req_valid` only after it has seen `req_ready` high. The bench draws channels, codes and batch flags at random from a fixed seed. It also drives directed requests with the all-zero, all-one and mid-scale codes and a batch of held loads, and it measures every bus interval in cycles against the parameters.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOW  = 3'd1,
        ST_HIGH = 3'd2,
        ST_LREG = 3'd3,
        ST_SEP  = 3'd4,
        ST_LDAL = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       sclk;
        logic       cs_n;
        logic       ldreg_n;
        logic       ldall_n;
        logic       hold;
    } seq_ctl_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/qdac_timer.sv
module qdac_timer #(
    parameter int unsigned TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R4: a running count only moves down by one unless it is reloaded
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - TW'(1)));

endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb,
    output logic         last
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [W-1:0]  word_d, word_q;
    logic [CW-1:0] rem_d, rem_q;

    always_comb begin
        word_d = word_q;
        rem_d  = rem_q;
        if (load) begin
            word_d = load_val;
            rem_d  = CW'(W);
        end else if (shift) begin
            word_d = {word_q[W-2:0], 1'b0};
            rem_d  = rem_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            rem_q  <= '0;
        end else begin
            word_q <= word_d;
            rem_q  <= rem_d;
        end
    end

    assign msb  = word_q[W-1];
    assign last = (rem_q == CW'(1));

    // R2: never shift past the end of the frame
    p_shift_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> (rem_q > CW'(1)));

endmodule

// File: rtl/qdac_seq.sv
module qdac_seq
    import qdac_pkg::*;
#(
    parameter int unsigned CH_W           = 2,
    parameter int unsigned CODE_W         = 12,
    parameter int unsigned SETUP_CYC      = 3,
    parameter int unsigned HOLD_CYC       = 2,
    parameter int unsigned HIGH_CYC       = 3,
    parameter int unsigned LOW_CYC        = 5,
    parameter int unsigned CS_LEAD_CYC    = 6,
    parameter int unsigned CS_LAG_CYC     = 2,
    parameter int unsigned LREG_SETUP_CYC = 4,
    parameter int unsigned LREG_AFTER_CYC = 2,
    parameter int unsigned LREG_LOW_CYC   = 5,
    parameter int unsigned LDALL_LOW_CYC  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CH_W-1:0]   req_chan,
    input  logic [CODE_W-1:0] req_code,
    input  logic              req_hold,
    output logic              busy,
    output logic              dac_sclk,
    output logic              dac_cs_n,
    output logic              dac_sdo,
    output logic              dac_ldreg_n,
    output logic              dac_ldall_n
);
    localparam int unsigned PAD_W   = 2;
    localparam int unsigned FRAME_W = CH_W + PAD_W + CODE_W;

    // phase lengths, each the largest of the minima that end in it
    localparam int unsigned LOW_N     = umax(umax(LOW_CYC, SETUP_CYC), 1);
    localparam int unsigned LOW_FIRST = umax(umax(LOW_N, CS_LEAD_CYC), LREG_SETUP_CYC);
    localparam int unsigned HIGH_N    = umax(umax(HIGH_CYC, HOLD_CYC), 1);
    localparam int unsigned HIGH_LAST = umax(umax(HIGH_N, CS_LAG_CYC), LREG_AFTER_CYC);
    localparam int unsigned LREG_N    = umax(LREG_LOW_CYC, 1);
    localparam int unsigned LDALL_N   = umax(LDALL_LOW_CYC, 1);
    localparam int unsigned MAX_N     = umax(umax(umax(LOW_FIRST, HIGH_LAST), LREG_N), LDALL_N);
    localparam int unsigned TW        = $clog2(MAX_N + 1);

    seq_ctl_t ctl_d, ctl_q;

    logic          t_load;
    logic [TW-1:0] t_val;
    logic          t_expired;
    logic          sh_load;
    logic          sh_shift;
    logic          sh_msb;
    logic          sh_last;
    logic [FRAME_W-1:0] frame;

    assign frame = {req_chan, {PAD_W{1'b0}}, req_code};

    qdac_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    qdac_shifter #(.W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (frame),
        .shift    (sh_shift),
        .msb      (sh_msb),
        .last     (sh_last)
    );

    always_comb begin
        ctl_d    = ctl_q;
        t_load   = 1'b0;
        t_val    = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st   = ST_LOW;
                    ctl_d.cs_n = 1'b0;
                    ctl_d.sclk = 1'b0;
                    ctl_d.hold = req_hold;
                    sh_load    = 1'b1;
                    t_load     = 1'b1;
                    t_val      = TW'(LOW_FIRST - 1);
                end
            end
            ST_LOW: begin
                if (t_expired) begin
                    ctl_d.st   = ST_HIGH;
                    ctl_d.sclk = 1'b1;
                    t_load     = 1'b1;
                    t_val      = sh_last ? TW'(HIGH_LAST - 1) : TW'(HIGH_N - 1);
                end
            end
            ST_HIGH: begin
                if (t_expired) begin
                    t_load = 1'b1;
                    if (sh_last) begin
                        ctl_d.st      = ST_LREG;
                        ctl_d.cs_n    = 1'b1;
                        ctl_d.ldreg_n = 1'b0;
                        t_val         = TW'(LREG_N - 1);
                    end else begin
                        ctl_d.st   = ST_LOW;
                        ctl_d.sclk = 1'b0;
                        sh_shift   = 1'b1;
                        t_val      = TW'(LOW_N - 1);
                    end
                end
            end
            ST_LREG: begin
                if (t_expired) begin
                    ctl_d.ldreg_n = 1'b1;
                    ctl_d.st      = ctl_q.hold ? ST_IDLE : ST_SEP;
                end
            end
            ST_SEP: begin
                ctl_d.st      = ST_LDAL;
                ctl_d.ldall_n = 1'b0;
                t_load        = 1'b1;
                t_val         = TW'(LDALL_N - 1);
            end
            ST_LDAL: begin
                if (t_expired) begin
                    ctl_d.ldall_n = 1'b1;
                    ctl_d.st      = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, sclk: 1'b1, cs_n: 1'b1, ldreg_n: 1'b1,
                       ldall_n: 1'b1, hold: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready   = (ctl_q.st == ST_IDLE);
    assign busy        = (ctl_q.st != ST_IDLE);
    assign dac_sclk    = ctl_q.sclk;
    assign dac_cs_n    = ctl_q.cs_n;
    assign dac_sdo     = sh_msb;
    assign dac_ldreg_n = ctl_q.ldreg_n;
    assign dac_ldall_n = ctl_q.ldall_n;

    // R1: idle means every bus line is at rest
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE) |-> (dac_sclk && dac_cs_n && dac_ldreg_n && dac_ldall_n));

    // R3: data does not move while the clock stays high inside a frame
    p_sdo_steady_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && dac_sclk && $past(dac_sclk) && !$past(dac_cs_n)) |-> $stable(dac_sdo));

    // R5: select only rises with the clock high
    p_cs_rise_clk_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_cs_n) |-> dac_sclk);

    // R6: register-load strobe stays high during shifting
    p_ldreg_high_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_cs_n |-> dac_ldreg_n);

    // R7: the two strobes never overlap
    p_strobes_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_ldall_n |-> (dac_ldreg_n && dac_cs_n));

    // R7: a batched request never pulses the all-load strobe
    p_hold_no_ldall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.hold && ctl_q.st != ST_IDLE) |-> dac_ldall_n);

    // R8: acceptance makes the block busy and closes the handshake
    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && !req_ready));

endmodule

// File: tb/sim_qdac_seq.sv
`timescale 1ns/1ps
module sim_qdac_seq;
    localparam int SETUP  = 5;
    localparam int HOLD   = 4;
    localparam int HI     = 6;
    localparam int LO     = 10;
    localparam int CSLEAD = 11;
    localparam int CSLAG  = 3;
    localparam int LRSET  = 8;
    localparam int LRAFT  = 3;
    localparam int LRLOW  = 9;
    localparam int LALOW  = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0]  req_chan = '0;
    logic [11:0] req_code = '0;
    logic req_hold = 1'b0;
    logic busy, dac_sclk, dac_cs_n, dac_sdo, dac_ldreg_n, dac_ldall_n;

    always #2.5 clk = ~clk;

    qdac_seq #(
        .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .HIGH_CYC(HI), .LOW_CYC(LO),
        .CS_LEAD_CYC(CSLEAD), .CS_LAG_CYC(CSLAG), .LREG_SETUP_CYC(LRSET),
        .LREG_AFTER_CYC(LRAFT), .LREG_LOW_CYC(LRLOW), .LDALL_LOW_CYC(LALOW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_code(req_code), .req_hold(req_hold), .busy(busy),
        .dac_sclk(dac_sclk), .dac_cs_n(dac_cs_n), .dac_sdo(dac_sdo),
        .dac_ldreg_n(dac_ldreg_n), .dac_ldall_n(dac_ldall_n)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // bus monitor, all intervals in system clock cycles
    int cyc = 0;
    logic p_sclk, p_cs, p_ldr, p_lda, p_sdo;
    int t_rise = -1000, t_fall = -1000, t_csf = -1000, t_sdo = -1000;
    int t_lrr = -1000, t_lrf = -1000, t_laf = -1000;
    int bits = 0, nbits_last = 0, frames = 0, ldr_pulses = 0, lda_pulses = 0;
    logic [15:0] shreg = '0, last_frame = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_sclk = dac_sclk; p_cs = dac_cs_n; p_ldr = dac_ldreg_n;
            p_lda = dac_ldall_n; p_sdo = dac_sdo;
        end else begin
            cyc++;
            if (dac_sdo !== p_sdo) begin
                if (!dac_cs_n && bits > 0)
                    chk(cyc - t_rise >= HOLD, "R3", "data hold", cyc - t_rise, HOLD);
                t_sdo = cyc;
            end
            if (p_cs && !dac_cs_n) begin
                t_csf = cyc;
                bits = 0;
            end
            if (!p_sclk && dac_sclk) begin
                chk(!dac_cs_n, "R5", "rise with select low", dac_cs_n, 0);
                chk(cyc - t_sdo >= SETUP, "R3", "data setup", cyc - t_sdo, SETUP);
                chk(cyc - t_fall >= LO, "R4", "clock low", cyc - t_fall, LO);
                if (bits == 0)
                    chk(cyc - t_csf >= CSLEAD, "R5", "select lead", cyc - t_csf, CSLEAD);
                chk(dac_ldreg_n && (cyc - t_lrr >= LRSET), "R6", "ldreg setup",
                    cyc - t_lrr, LRSET);
                shreg = {shreg[14:0], dac_sdo};
                bits++;
                t_rise = cyc;
            end
            if (p_sclk && !dac_sclk) begin
                chk(cyc - t_rise >= HI, "R4", "clock high", cyc - t_rise, HI);
                t_fall = cyc;
            end
            if (!p_cs && dac_cs_n) begin
                chk(dac_sclk, "R5", "select rise clock level", dac_sclk, 1);
                chk(cyc - t_rise >= CSLAG, "R5", "select lag", cyc - t_rise, CSLAG);
                last_frame = shreg;
                nbits_last = bits;
                frames++;
            end
            if (p_ldr && !dac_ldreg_n) begin
                chk(dac_cs_n && (cyc - t_rise >= LRAFT), "R6", "ldreg after last rise",
                    cyc - t_rise, LRAFT);
                t_lrf = cyc;
            end
            if (!p_ldr && dac_ldreg_n) begin
                chk(cyc - t_lrf >= LRLOW, "R6", "ldreg width", cyc - t_lrf, LRLOW);
                ldr_pulses++;
                t_lrr = cyc;
            end
            if (p_lda && !dac_ldall_n) begin
                chk(dac_ldreg_n && cyc > t_lrr, "R7", "ldall after ldreg", cyc - t_lrr, 1);
                t_laf = cyc;
            end
            if (!p_lda && dac_ldall_n) begin
                chk(cyc - t_laf >= LALOW, "R7", "ldall width", cyc - t_laf, LALOW);
                lda_pulses++;
            end
            p_sclk = dac_sclk; p_cs = dac_cs_n; p_ldr = dac_ldreg_n;
            p_lda = dac_ldall_n; p_sdo = dac_sdo;
        end
    end

    function automatic logic [15:0] exp_frame(input logic [1:0] ch, input logic [11:0] code);
        return {ch, 2'b00, code};
    endfunction

    task automatic check_idle(input string tag);
        chk(dac_sclk && dac_cs_n && dac_ldreg_n && dac_ldall_n, "R1", tag,
            {dac_sclk, dac_cs_n, dac_ldreg_n, dac_ldall_n}, 15);
        chk(req_ready && !busy, "R1", "ready/busy at idle", {req_ready, busy}, 2);
    endtask

    task automatic send(input logic [1:0] ch, input logic [11:0] code, input logic hold);
        int f0, l0, a0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        f0 = frames; l0 = ldr_pulses; a0 = lda_pulses;
        req_valid = 1'b1; req_chan = ch; req_code = code; req_hold = hold;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy && !req_ready, "R8", "busy after accept", {busy, req_ready}, 2);
        while (busy) begin
            chk(!req_ready, "R8", "ready while busy", req_ready, 0);
            @(negedge clk);
        end
        @(negedge clk);
        #1;
        chk(frames == f0 + 1, "R2", "frame count", frames - f0, 1);
        chk(nbits_last == 16, "R2", "rising edges per frame", nbits_last, 16);
        chk(last_frame == exp_frame(ch, code), "R2", "frame bits",
            int'(last_frame), int'(exp_frame(ch, code)));
        chk(ldr_pulses == l0 + 1, "R6", "ldreg pulses", ldr_pulses - l0, 1);
        chk(lda_pulses == a0 + (hold ? 0 : 1), "R7", "ldall pulses",
            lda_pulses - a0, hold ? 0 : 1);
        check_idle("lines idle after request");
    endtask

    initial begin
        void'($urandom(32'h0051_7A3C));
        repeat (4) @(negedge clk);
        check_idle("reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("after reset release");

        // directed corner codes on each channel
        send(2'd0, 12'h000, 1'b0);
        send(2'd1, 12'hFFF, 1'b0);
        send(2'd2, 12'h800, 1'b0);
        send(2'd3, 12'h7FF, 1'b0);
        send(2'd2, 12'hA5A, 1'b0);

        // batch: three held loads, then one releasing load
        begin
            int a_start;
            a_start = lda_pulses;
            send(2'd0, 12'h123, 1'b1);
            send(2'd1, 12'h456, 1'b1);
            send(2'd3, 12'h789, 1'b1);
            chk(lda_pulses == a_start, "R7", "no ldall during batch", lda_pulses - a_start, 0);
            send(2'd2, 12'hABC, 1'b0);
            chk(lda_pulses == a_start + 1, "R7", "single ldall closes batch",
                lda_pulses - a_start, 1);
        end

        // random traffic
        for (int i = 0; i < 40; i++) begin
            logic [1:0]  ch;
            logic [11:0] cd;
            logic        hd;
            ch = 2'($urandom_range(0, 3));
            cd = 12'($urandom_range(0, 4095));
            hd = ($urandom_range(0, 3) == 0);
            send(ch, cd, hd);
        end
        send(2'd1, 12'h001, 1'b0);

        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL R8 watchdog: actual %0d expected %0d", 1, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule